// File: doc/BRIEF.md
# Flash Bank Access and Protection Checker

This block sits in front of a four-bank NOR-style flash array that can read one bank while a program or erase runs in another. For every request it decodes the 22-bit word address into a bank and a sector, and decides whether the access may go ahead. It weighs the state of the embedded operation, the write-protect pin level and a per-sector protection bit that it holds internally. The flash cells, the high-voltage supplies and the command parser are outside the block. The parser gives the block the current operation state, that operation's bank and sector, and the kind of each new request.

A request is a single-cycle `req_vld` pulse with a kind (read, program, erase) and an address. One cycle later the block returns a registered response. The response carries the decoded bank and sector, the read and write permissions, the effective protection of the sector, a bypass indication and an error pulse when the request is refused. The protection bits are changed one at a time through a set/clear port.

Top module: `flash_access_gate`

## Requirements
- R1: The bank comes from address bits 21:19. Code 000 gives bank 0, codes 001 to 011 give bank 1, codes 100 to 110 give bank 2, and code 111 gives bank 3.
- R2: Let s be address bits 21:12. For s below 8 the sector is s. For s of 1016 or more the sector is s − 882, which gives the top small sectors 134 to 141. For every other s the sector is (s >> 3) + 7. The sectors are numbered 0 to 141.
- R3: Each request produces exactly one `rsp_vld` pulse in the next cycle, and all response fields are registered. A cycle without a request produces neither `rsp_vld` nor `rsp_err`.
- R4: Operation states are encoded 00 idle, 01 programming, 10 erasing and 11 erase-suspended. When the state is idle, every read is allowed. While programming or erasing, a read to the operation's bank is refused and a read to any other bank is allowed.
- R5: Request kinds are encoded 00 read, 01 program, 10 erase and 11 illegal. While programming or erasing, every program and erase request is refused.
- R6: During erase suspend, reads and programs are allowed in every sector except the suspended sector, and erase requests are refused.
- R7: Pin levels are encoded 00 low, 01 high, 10 high-voltage, and 11 is treated as low. At the low level, sectors 0, 1, 140 and 141 are protected whatever their stored bit holds.
- R8: At the high level, every sector's protection equals its stored bit.
- R9: At the high-voltage level, no sector is protected and `rsp_bypass` is 1. At other levels `rsp_bypass` is 0.
- R10: A protected sector refuses both program and erase requests, and `rsp_prot` reports the effective protection of the addressed sector.
- R11: `rsp_err` pulses when a request is refused: a read with `rsp_rd_ok` low, or a program or erase with `rsp_wr_ok` low. `rsp_wr_ok` is 0 for read and illegal requests, and an illegal request always sets `rsp_err`.
- R12: After reset all stored protection bits are 0. A port write (`prot_set` = 1 sets, 0 clears) changes only sector `prot_idx`, and an index of 142 or more changes nothing. A request in the same cycle as the write is judged on the old bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_vld | input | 1 | Request strobe |
| req_kind | input | 2 | 00 read, 01 program, 10 erase, 11 illegal |
| req_addr | input | 22 | Word address |
| op_state | input | 2 | 00 idle, 01 programming, 10 erasing, 11 erase-suspended |
| op_bank | input | 2 | Bank of the running operation |
| op_sector | input | 8 | Sector of the running or suspended erase |
| wp_level | input | 2 | Pin level: 00 low, 01 high, 10 high-voltage |
| prot_we | input | 1 | Protection bit write strobe |
| prot_set | input | 1 | 1 sets, 0 clears |
| prot_idx | input | 8 | Sector to write |
| rsp_vld | output | 1 | Response valid |
| rsp_bank | output | 2 | Decoded bank |
| rsp_sector | output | 8 | Decoded sector |
| rsp_rd_ok | output | 1 | Read of this address is allowed |
| rsp_wr_ok | output | 1 | Requested program or erase is allowed |
| rsp_prot | output | 1 | Sector effectively protected |
| rsp_bypass | output | 1 | Unlock-bypass forced by high-voltage pin |
| rsp_err | output | 1 | Request refused |

## Verification
A protection-bit write and a request to the same sector can land in the same cycle. The bench provokes this by driving a set on a clear sector together with a program to that sector. It expects the program to be accepted on the old bit, and it expects the following program to be refused. A second overlap is the pin forcing of a boot sector against its stored bit. Sweeps at every pin level over sectors whose stored bits are set and clear show which of the two wins. The expected values come from the bench's own sector arithmetic and its own copy of the protection bits.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [1:0] {
    K_READ  = 2'b00,
    K_PROG  = 2'b01,
    K_ERASE = 2'b10,
    K_BAD   = 2'b11
  } req_kind_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_SUSP  = 2'b11
  } op_state_e;

  typedef enum logic [1:0] {
    WP_LOW  = 2'b00,
    WP_HIGH = 2'b01,
    WP_HV   = 2'b10,
    WP_RSVD = 2'b11
  } wp_level_e;

endpackage

// File: rtl/fg_addr_decode.sv
module fg_addr_decode #(
  parameter int SA_W        = 10,
  parameter int SMALL_W     = 3,
  parameter int BANK_CODE_W = 3,
  localparam int BIG_W  = SA_W - SMALL_W,
  localparam int NSMALL = 1 << SMALL_W,
  localparam int NSEC   = (1 << BIG_W) - 2 + 2 * NSMALL,
  localparam int SEC_W  = $clog2(NSEC)
) (
  input  logic [SA_W-1:0]  sa,
  output logic [1:0]       bank,
  output logic [SEC_W-1:0] sector,
  output logic             boot
);

  // Uneven bank split: lowest code alone, highest code alone,
  // lower half of the rest and upper half of the rest.
  function automatic logic [1:0] bank_of(input logic [BANK_CODE_W-1:0] c);
    if (c == '0)             return 2'd0;
    if (c == '1)             return 2'd3;
    if (!c[BANK_CODE_W-1])   return 2'd1;
    return 2'd2;
  endfunction

  // Small sectors at both ends, large ones in between.
  function automatic logic [SEC_W-1:0] sector_of(input logic [SA_W-1:0] s);
    logic [BIG_W-1:0]   big;
    logic [SMALL_W-1:0] low;
    big = s[SA_W-1:SMALL_W];
    low = s[SMALL_W-1:0];
    if (big == '0) return SEC_W'(low);
    if (big == '1) return SEC_W'(NSEC - NSMALL) + SEC_W'(low);
    return SEC_W'(big) + SEC_W'(NSMALL - 1);
  endfunction

  // The two lowest and two highest sectors are pin-lockable.
  function automatic logic is_boot(input logic [SEC_W-1:0] n);
    return (n == SEC_W'(0)) || (n == SEC_W'(1)) ||
           (n == SEC_W'(NSEC - 2)) || (n == SEC_W'(NSEC - 1));
  endfunction

  assign bank   = bank_of(sa[SA_W-1 -: BANK_CODE_W]);
  assign sector = sector_of(sa);
  assign boot   = is_boot(sector);

  // R2: decoded sector never leaves the numbered range
  always_comb begin
    a_r2_sector_in_range: assert (sector < SEC_W'(NSEC));
  end

endmodule

// File: rtl/fg_prot_store.sv
module fg_prot_store #(
  parameter int NSEC  = 142,
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             upd_set,
  input  logic [SEC_W-1:0] upd_idx,
  input  logic [SEC_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [NSEC-1:0] bits;

  for (genvar i = 0; i < NSEC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 bits[i] <= 1'b0;
      else if (upd_en && upd_idx == SEC_W'(i))    bits[i] <= upd_set;
    end
  end

  assign rd_bit = (rd_idx < SEC_W'(NSEC)) ? bits[rd_idx] : 1'b0;

  // R12: a set or clear lands on the addressed bit one cycle later
  a_r12_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_set && upd_idx < SEC_W'(NSEC)) |=> bits[$past(upd_idx)]);
  a_r12_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_set && upd_idx < SEC_W'(NSEC)) |=> !bits[$past(upd_idx)]);
  a_r12_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(bits));

endmodule

// File: rtl/fg_permit.sv
module fg_permit
  import flash_gate_pkg::*;
#(
  parameter int SEC_W = 8
) (
  input  req_kind_e        kind,
  input  logic [1:0]       bank,
  input  logic [SEC_W-1:0] sector,
  input  logic             boot,
  input  logic             stored,
  input  op_state_e        state,
  input  logic [1:0]       op_bank,
  input  logic [SEC_W-1:0] op_sector,
  input  wp_level_e        wp,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             prot,
  output logic             bypass,
  output logic             reject
);

  logic same_bank, same_sec, pin_lock;

  assign same_bank = (bank == op_bank);
  assign same_sec  = (sector == op_sector);
  assign pin_lock  = ((wp == WP_LOW) || (wp == WP_RSVD)) && boot;
  assign bypass    = (wp == WP_HV);
  assign prot      = bypass ? 1'b0 : (pin_lock | stored);

  always_comb begin
    unique case (state)
      OP_IDLE:           rd_ok = 1'b1;
      OP_PROG, OP_ERASE: rd_ok = !same_bank;
      OP_SUSP:           rd_ok = !same_sec;
      default:           rd_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (kind)
      K_PROG:  wr_ok = !prot && ((state == OP_IDLE) ||
                                 ((state == OP_SUSP) && !same_sec));
      K_ERASE: wr_ok = !prot && (state == OP_IDLE);
      default: wr_ok = 1'b0;
    endcase
  end

  assign reject = (kind == K_READ) ? !rd_ok : !wr_ok;

endmodule

// File: rtl/flash_access_gate.sv
module flash_access_gate
  import flash_gate_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int PAGE_W      = 12,
  parameter int SMALL_W     = 3,
  parameter int BANK_CODE_W = 3,
  localparam int SA_W   = ADDR_W - PAGE_W,
  localparam int BIG_W  = SA_W - SMALL_W,
  localparam int NSMALL = 1 << SMALL_W,
  localparam int NSEC   = (1 << BIG_W) - 2 + 2 * NSMALL,
  localparam int SEC_W  = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        op_state,
  input  logic [1:0]        op_bank,
  input  logic [SEC_W-1:0]  op_sector,
  input  logic [1:0]        wp_level,
  input  logic              prot_we,
  input  logic              prot_set,
  input  logic [SEC_W-1:0]  prot_idx,
  output logic              rsp_vld,
  output logic [1:0]        rsp_bank,
  output logic [SEC_W-1:0]  rsp_sector,
  output logic              rsp_rd_ok,
  output logic              rsp_wr_ok,
  output logic              rsp_prot,
  output logic              rsp_err,
  output logic              rsp_bypass
);

  // Offset inside a 4-Kword page plays no part in any decision.
  logic unused_page_offset;
  assign unused_page_offset = ^req_addr[PAGE_W-1:0];

  logic [1:0]       dec_bank;
  logic [SEC_W-1:0] dec_sector;
  logic             dec_boot;
  logic             stored_bit;
  logic             pm_rd_ok, pm_wr_ok, pm_prot, pm_bypass, pm_reject;

  fg_addr_decode #(
    .SA_W(SA_W), .SMALL_W(SMALL_W), .BANK_CODE_W(BANK_CODE_W)
  ) u_decode (
    .sa     (req_addr[ADDR_W-1:PAGE_W]),
    .bank   (dec_bank),
    .sector (dec_sector),
    .boot   (dec_boot)
  );

  fg_prot_store #(.NSEC(NSEC), .SEC_W(SEC_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (prot_we),
    .upd_set (prot_set),
    .upd_idx (prot_idx),
    .rd_idx  (dec_sector),
    .rd_bit  (stored_bit)
  );

  fg_permit #(.SEC_W(SEC_W)) u_permit (
    .kind      (req_kind_e'(req_kind)),
    .bank      (dec_bank),
    .sector    (dec_sector),
    .boot      (dec_boot),
    .stored    (stored_bit),
    .state     (op_state_e'(op_state)),
    .op_bank   (op_bank),
    .op_sector (op_sector),
    .wp        (wp_level_e'(wp_level)),
    .rd_ok     (pm_rd_ok),
    .wr_ok     (pm_wr_ok),
    .prot      (pm_prot),
    .bypass    (pm_bypass),
    .reject    (pm_reject)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld    <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_bank   <= '0;
      rsp_sector <= '0;
      rsp_rd_ok  <= 1'b0;
      rsp_wr_ok  <= 1'b0;
      rsp_prot   <= 1'b0;
      rsp_bypass <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
      rsp_err <= req_vld && pm_reject;
      if (req_vld) begin
        rsp_bank   <= dec_bank;
        rsp_sector <= dec_sector;
        rsp_rd_ok  <= pm_rd_ok;
        rsp_wr_ok  <= pm_wr_ok;
        rsp_prot   <= pm_prot;
        rsp_bypass <= pm_bypass;
      end
    end
  end

  // R3: one response per request, nothing without a request
  a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_vld && !rsp_err));
  // R4: the busy bank refuses reads
  a_r4_busy_bank_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'b00 && (op_state == 2'b01 || op_state == 2'b10)
     && dec_bank == op_bank) |=> (rsp_err && !rsp_rd_ok));
  // R5: a second write operation is never started
  a_r5_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind != 2'b00 && (op_state == 2'b01 || op_state == 2'b10))
    |=> !rsp_wr_ok);
  // R6: no erase while suspended
  a_r6_no_erase_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'b10 && op_state == 2'b11) |=> rsp_err);
  // R7: low pin locks boot sectors
  a_r7_pin_locks_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (wp_level == 2'b00 || wp_level == 2'b11) && dec_boot)
    |=> rsp_prot);
  // R9: high-voltage level lifts all protection
  a_r9_hv_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && wp_level == 2'b10) |=> (!rsp_prot && rsp_bypass));
  // R10: protection blocks program and erase
  a_r10_prot_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_prot) |-> !rsp_wr_ok);
  // R11: an illegal kind is always refused
  a_r11_illegal_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'b11) |=> (rsp_err && !rsp_wr_ok));

endmodule

// File: tb/tb_flash_access_gate.sv
module tb_flash_access_gate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [1:0]  req_kind;
  logic [21:0] req_addr;
  logic [1:0]  op_state, op_bank, wp_level;
  logic [7:0]  op_sector;
  logic        prot_we, prot_set;
  logic [7:0]  prot_idx;
  logic        rsp_vld, rsp_rd_ok, rsp_wr_ok, rsp_prot, rsp_err, rsp_bypass;
  logic [1:0]  rsp_bank;
  logic [7:0]  rsp_sector;

  int n_chk  = 0;
  int n_fail = 0;
  bit pm [142];

  always #5 clk = ~clk;

  flash_access_gate dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
    .req_addr(req_addr), .op_state(op_state), .op_bank(op_bank),
    .op_sector(op_sector), .wp_level(wp_level), .prot_we(prot_we),
    .prot_set(prot_set), .prot_idx(prot_idx), .rsp_vld(rsp_vld),
    .rsp_bank(rsp_bank), .rsp_sector(rsp_sector), .rsp_rd_ok(rsp_rd_ok),
    .rsp_wr_ok(rsp_wr_ok), .rsp_prot(rsp_prot), .rsp_err(rsp_err),
    .rsp_bypass(rsp_bypass)
  );

  function automatic int m_bank(input int a);
    int c;
    c = a >> 19;
    if (c == 0) return 0;
    if (c <= 3) return 1;
    if (c <= 6) return 2;
    return 3;
  endfunction

  function automatic int m_sec(input int a);
    int s;
    s = a >> 12;
    if (s < 8)     return s;
    if (s >= 1016) return s - 882;
    return (s >> 3) + 7;
  endfunction

  function automatic int addr_of(input int s, input int off);
    if (s < 8)    return (s << 12) | (off & 32'hfff);
    if (s >= 134) return ((s + 882) << 12) | (off & 32'hfff);
    return ((s - 7) << 15) | (off & 32'h7fff);
  endfunction

  function automatic logic [15:0] expect_rsp(input int kind, input int a);
    int  b, s;
    bit  boot, pr, rd, wr, er, by;
    b    = m_bank(a);
    s    = m_sec(a);
    boot = (s == 0 || s == 1 || s == 140 || s == 141);
    by   = (wp_level == 2'b10);
    pr   = by ? 1'b0 : (((wp_level != 2'b01) && boot) || pm[s]);
    if (op_state == 2'b00)      rd = 1'b1;
    else if (op_state == 2'b11) rd = (s != int'(op_sector));
    else                        rd = (b != int'(op_bank));
    if (kind == 1)
      wr = !pr && (op_state == 2'b00 || (op_state == 2'b11 && s != int'(op_sector)));
    else if (kind == 2)
      wr = !pr && (op_state == 2'b00);
    else
      wr = 1'b0;
    er = (kind == 0) ? !rd : !wr;
    return {1'b1, 2'(b), 8'(s), rd, wr, pr, er, by};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] got_rsp();
    return {rsp_vld, rsp_bank, rsp_sector, rsp_rd_ok, rsp_wr_ok,
            rsp_prot, rsp_err, rsp_bypass};
  endfunction

  task automatic req(input int kind, input int a, input string tag);
    logic [15:0] exp;
    @(negedge clk);
    req_vld  = 1'b1;
    req_kind = 2'(kind);
    req_addr = 22'(a);
    exp      = expect_rsp(kind, a);
    @(negedge clk);
    req_vld  = 1'b0;
    check(tag, got_rsp(), exp);
  endtask

  task automatic prot_write(input bit set, input int idx);
    @(negedge clk);
    prot_we  = 1'b1;
    prot_set = set;
    prot_idx = 8'(idx);
    @(negedge clk);
    prot_we  = 1'b0;
    if (idx < 142) pm[idx] = set;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] exp;
    rst_n = 1'b0; req_vld = 1'b0; req_kind = 2'b00; req_addr = '0;
    op_state = 2'b00; op_bank = 2'b00; op_sector = 8'd0; wp_level = 2'b01;
    prot_we = 1'b0; prot_set = 1'b0; prot_idx = 8'd0;
    repeat (3) @(negedge clk);
    // R3: reset state of the response
    check("R3 reset", {10'd0, rsp_vld, rsp_rd_ok, rsp_wr_ok, rsp_prot, rsp_err, rsp_bypass}, 16'd0);
    rst_n = 1'b1;

    // R1 R2: every sector-address value, idle, reads
    for (int sa = 0; sa < 1024; sa++)
      req(0, (sa << 12) | ((sa * 37) & 32'hfff), "R1 R2 decode sweep");

    // R3: quiet cycle after a request
    @(negedge clk);
    check("R3 no request", {14'd0, rsp_vld, rsp_err}, 16'd0);

    // R12: all bits clear after reset
    for (int s = 0; s < 142; s++) req(1, addr_of(s, s * 11), "R12 reset clear");

    // store bits on a pattern, sectors 1 and 141 left clear
    for (int s = 0; s < 142; s++)
      if (s % 5 == 0) prot_write(1'b1, s);

    wp_level = 2'b01;
    for (int s = 0; s < 142; s++) begin
      req(1, addr_of(s, s), "R8 R10 program pin high");
      req(2, addr_of(s, s), "R10 erase pin high");
    end
    wp_level = 2'b00;
    for (int s = 0; s < 142; s++) req(1, addr_of(s, 3 * s), "R7 program pin low");
    wp_level = 2'b11;
    req(1, addr_of(1, 0), "R7 reserved level");
    req(2, addr_of(141, 0), "R7 reserved level");
    wp_level = 2'b10;
    for (int s = 0; s < 142; s++) req(2, addr_of(s, 5 * s), "R9 erase high-voltage");
    wp_level = 2'b01;

    for (int s = 0; s < 142; s++)
      if (pm[s]) prot_write(1'b0, s);

    // R4 R5: busy bank during program and erase
    for (int st = 1; st <= 2; st++)
      for (int ob = 0; ob < 4; ob++) begin
        op_state = 2'(st);
        op_bank  = 2'(ob);
        for (int s = 0; s < 142; s++) begin
          req(0, addr_of(s, 7 * s), "R4 read while busy");
          req((s % 2) + 1, addr_of(s, s), "R5 write while busy");
        end
      end

    // R6: erase suspend
    op_state = 2'b11;
    for (int k = 0; k < 4; k++) begin
      int os;
      os = (k == 0) ? 0 : (k == 1) ? 5 : (k == 2) ? 77 : 141;
      op_sector = 8'(os);
      op_bank   = 2'(m_bank(addr_of(os, 0)));
      for (int s = 0; s < 142; s++) begin
        req(0, addr_of(s, s), "R6 read in suspend");
        req(1, addr_of(s, s), "R6 program in suspend");
        req(2, addr_of(s, s), "R6 erase in suspend");
      end
    end
    op_state = 2'b00;

    // R11: illegal kind
    req(3, addr_of(50, 0), "R11 illegal kind");
    req(3, addr_of(138, 9), "R11 illegal kind");

    // R12: out-of-range index changes nothing
    prot_write(1'b1, 200);
    prot_write(1'b1, 255);
    prot_write(1'b1, 142);
    for (int s = 0; s < 142; s++) req(1, addr_of(s, 2 * s), "R12 out of range ignored");

    // R12: write and request to one sector in the same cycle
    @(negedge clk);
    prot_we  = 1'b1; prot_set = 1'b1; prot_idx = 8'd20;
    req_vld  = 1'b1; req_kind = 2'b01; req_addr = 22'(addr_of(20, 0));
    exp      = expect_rsp(1, addr_of(20, 0));
    @(negedge clk);
    prot_we  = 1'b0; req_vld = 1'b0;
    check("R12 same-cycle old bit", got_rsp(), exp);
    pm[20] = 1'b1;
    req(1, addr_of(20, 4), "R12 new bit seen");
    prot_write(1'b0, 20);
    req(2, addr_of(20, 4), "R12 cleared bit");

    finish_run();
  end

endmodule